// File: doc/BRIEF.md
# Event entry and return controller

This block sits beside the fetch stage of a small processor core. It handles the status-register and program-counter side of taking and leaving events. Each cycle it looks at four interrupt levels, a vector of exception sources, a debug request and two return strobes. It compares them against the current status word and decides whether to redirect the core.

When it accepts an entry, it saves the incoming status word and program counter into a return pair that belongs to the context being entered. It then rewrites the mode and mask fields and presents the handler address for one cycle. When it accepts a return, it reads the pair of the context being left and hands that state back. The core is expected to load `sr_out` and `pc_out` at the end of the redirect cycle. A source keeps its request raised until it sees its acknowledge.

Debug has a return pair of its own. Entering debug therefore never overwrites the state that the exception context saved.

The status word layout used throughout:
- bits 2:0 are the mode: 0 application, 1 supervisor, 2 to 5 interrupt levels 0 to 3, 6 exception, 7 reserved.
- bit 3 is the global interrupt mask.
- bits 7:4 mask interrupt levels 0 to 3.
- bit 8 is the exception mask.
- bit 9 is the debug mask.
- bit 10 is the debug-active flag.

Top module: `evt_ctl`

## Requirements
- R1: After reset, `redir_vld`, `irq_ack`, `exc_ack` and `dbg_ack` are low, and `sr_out` and `pc_out` are zero.
- R2: An accepted event or return raises `redir_vld` for exactly the cycle after acceptance. In that cycle every input is ignored. At most one acknowledge bit is high, and only in that cycle.
- R3: When more than one is possible in the same cycle, the order is: debug return, then event return, then debug entry, then exception, then interrupt.
- R4: Debug entry happens when `dbg_req` is high and status bits 9 and 10 are both clear. The output status is the input with bit 10 set and the mode set to 6, and `pc_out` is `DBG_VEC`.
- R5: A debug request is ignored while status bit 9 or bit 10 is set. It gets no redirect and no acknowledge.
- R6: An exception is accepted when any `exc_req` bit is set and status bit 8 is clear. The lowest index wins. The output status has mode 6 with bits 8 and 3 set, and `pc_out` is `EXC_BASE + index*VEC_STRIDE`.
- R7: Interrupt level k is eligible when it is pending, status bit 3 and bit 4+k are clear, and k+1 exceeds the rank of the current mode. Ranks are: application and supervisor 0, level j is j+1, exception 5, reserved 7. The highest eligible level wins, the mode becomes 2+k, and `pc_out` is `INT_BASE + k*VEC_STRIDE`.
- R8: Every entry stores `sr_in` and `pc_in` in a return pair chosen by the new context. There is one pair per interrupt level, one for exceptions and one for debug. An entry leaves the other pairs untouched.
- R9: An event return in modes 2 to 6 outputs the pair of the current mode. In modes 0, 1 and 7 it is ignored.
- R10: A debug return with status bit 10 set outputs the debug pair. With bit 10 clear it is ignored.
- R11: A request that is not accepted gets no acknowledge, so it stays pending at its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 4 | Interrupt requests, one per level (3 is highest) |
| exc_req | input | NUM_EXC | Exception source requests |
| dbg_req | input | 1 | Debug request |
| ev_ret | input | 1 | Event-return strobe |
| dbg_ret | input | 1 | Debug-return strobe |
| sr_in | input | SR_W | Current status word |
| pc_in | input | PC_W | Current program counter |
| redir_vld | output | 1 | Redirect valid, one cycle per accepted event or return |
| sr_out | output | SR_W | Status word to load on redirect |
| pc_out | output | PC_W | Program counter to load on redirect |
| irq_ack | output | 4 | Acknowledge of the accepted interrupt level |
| exc_ack | output | NUM_EXC | Acknowledge of the accepted exception source |
| dbg_ack | output | 1 | Acknowledge of the accepted debug request |

## Verification
Directed sequences cover each arbitration boundary:
- a masked debug request, to separate mask gating from priority;
- an interrupt at the same level as the current mode, to separate the strict rank test from a greater-or-equal one;
- a return strobe together with an exception, to confirm that the return wins;
- a debug entry made from exception mode, followed by an exception return, to show that the two return pairs stay separate.

Constrained-random status words, request vectors and strobes then sweep every mode and mask combination against a bench model that tracks all six return pairs. A wrong slot index or a stale pair therefore shows up as a mismatched restore.

// File: rtl/evt_pkg.sv
package evt_pkg;
   // status word field positions
   localparam int SR_GM     = 3;
   localparam int SR_IM_LSB = 4;
   localparam int SR_EM     = 8;
   localparam int SR_DM     = 9;
   localparam int SR_DBG    = 10;
   localparam int SR_MIN_W  = 11;

   localparam int NUM_LVL   = 4;
   localparam int NSLOT     = 6;   // four levels, exception, debug
   localparam int SLOT_EXC  = 4;
   localparam int SLOT_DBG  = 5;
   localparam int SLOT_W    = 3;

   typedef enum logic [2:0] {
      MD_APP  = 3'd0,
      MD_SUP  = 3'd1,
      MD_INT0 = 3'd2,
      MD_INT1 = 3'd3,
      MD_INT2 = 3'd4,
      MD_INT3 = 3'd5,
      MD_EXC  = 3'd6,
      MD_RSV  = 3'd7
   } mode_e;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_RETD,
      EV_RETE,
      EV_DBG,
      EV_EXC,
      EV_INT
   } ev_e;

   function automatic logic [2:0] mode_rank(input logic [2:0] md);
      logic [2:0] r;
      case (md)
         3'd0, 3'd1: r = 3'd0;
         3'd2:       r = 3'd1;
         3'd3:       r = 3'd2;
         3'd4:       r = 3'd3;
         3'd5:       r = 3'd4;
         3'd6:       r = 3'd5;
         default:    r = 3'd7;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/evt_arb.sv
module evt_arb
   import evt_pkg::*;
#(
   parameter int SR_W          = 16,
   parameter int NUM_EXC       = 8,
   parameter int EXC_LOW_FIRST = 1,
   localparam int EI_W         = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1
) (
   input  logic               hold,
   input  logic [SR_W-1:0]    sr,
   input  logic [NUM_LVL-1:0] irq_req,
   input  logic [NUM_EXC-1:0] exc_req,
   input  logic               dbg_req,
   input  logic               ev_ret,
   input  logic               dbg_ret,
   output ev_e                ev,
   output logic [1:0]         lvl,
   output logic [EI_W-1:0]    exc_idx
);
   logic [2:0]         md;
   logic [2:0]         rank;
   logic [NUM_LVL-1:0] elig;

   assign md   = sr[2:0];
   assign rank = mode_rank(md);

   // interrupt eligibility per level
   generate
      for (genvar k = 0; k < NUM_LVL; k++) begin : g_elig
         assign elig[k] = irq_req[k] && !sr[SR_GM] && !sr[SR_IM_LSB+k]
                          && (3'(k + 1) > rank);
      end
   endgenerate

   always_comb begin
      lvl = 2'd0;
      for (int k = 0; k < NUM_LVL; k++)
         if (elig[k]) lvl = 2'(k);
   end

   // exception source selection, direction picked by parameter
   generate
      if (EXC_LOW_FIRST != 0) begin : g_exc_low
         always_comb begin
            exc_idx = '0;
            for (int i = NUM_EXC - 1; i >= 0; i--)
               if (exc_req[i]) exc_idx = EI_W'(i);
         end
      end else begin : g_exc_high
         always_comb begin
            exc_idx = '0;
            for (int i = 0; i < NUM_EXC; i++)
               if (exc_req[i]) exc_idx = EI_W'(i);
         end
      end
   endgenerate

   always_comb begin
      ev = EV_NONE;
      if (!hold) begin
         if (dbg_ret && sr[SR_DBG])
            ev = EV_RETD;
         else if (ev_ret && md >= 3'd2 && md <= 3'd6)
            ev = EV_RETE;
         else if (dbg_req && !sr[SR_DM] && !sr[SR_DBG])
            ev = EV_DBG;
         else if ((|exc_req) && !sr[SR_EM])
            ev = EV_EXC;
         else if (|elig)
            ev = EV_INT;
      end
   end
endmodule

// File: rtl/evt_ctx_store.sv
module evt_ctx_store
   import evt_pkg::*;
#(
   parameter int PC_W = 32,
   parameter int SR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [SR_W-1:0]   wr_sr,
   input  logic [PC_W-1:0]   wr_pc,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [SR_W-1:0]   rd_sr,
   output logic [PC_W-1:0]   rd_pc
);
   logic [SR_W-1:0] rs_v [NSLOT];
   logic [PC_W-1:0] ra_v [NSLOT];

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         logic [SR_W-1:0] rs_q;
         logic [PC_W-1:0] ra_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rs_q <= '0;
               ra_q <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(s)) begin
               rs_q <= wr_sr;
               ra_q <= wr_pc;
            end
         end
         assign rs_v[s] = rs_q;
         assign ra_v[s] = ra_q;
      end
   endgenerate

   always_comb begin
      rd_sr = '0;
      rd_pc = '0;
      for (int s = 0; s < NSLOT; s++)
         if (rd_slot == SLOT_W'(s)) begin
            rd_sr = rs_v[s];
            rd_pc = ra_v[s];
         end
   end

   // R8
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_slot) < NSLOT));
endmodule

// File: rtl/evt_ctl.sv
module evt_ctl
   import evt_pkg::*;
#(
   parameter int          PC_W          = 32,
   parameter int          SR_W          = 16,
   parameter int          NUM_EXC       = 8,
   parameter int          EXC_LOW_FIRST = 1,
   parameter int unsigned EXC_BASE      = 32'h0000_0100,
   parameter int unsigned INT_BASE      = 32'h0000_0200,
   parameter int unsigned VEC_STRIDE    = 8,
   parameter int unsigned DBG_VEC       = 32'h0000_0080,
   localparam int         EI_W          = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         irq_req,
   input  logic [NUM_EXC-1:0] exc_req,
   input  logic               dbg_req,
   input  logic               ev_ret,
   input  logic               dbg_ret,
   input  logic [SR_W-1:0]    sr_in,
   input  logic [PC_W-1:0]    pc_in,
   output logic               redir_vld,
   output logic [SR_W-1:0]    sr_out,
   output logic [PC_W-1:0]    pc_out,
   output logic [3:0]         irq_ack,
   output logic [NUM_EXC-1:0] exc_ack,
   output logic               dbg_ack
);
   generate
      if (SR_W < SR_MIN_W) begin : g_bad_sr
         $error("SR_W too narrow for the status layout");
      end
      if (NUM_EXC < 1) begin : g_bad_exc
         $error("NUM_EXC must be at least 1");
      end
      if (PC_W < 8) begin : g_bad_pc
         $error("PC_W must be at least 8");
      end
   endgenerate

   ev_e               ev;
   logic [1:0]        lvl;
   logic [EI_W-1:0]   exc_idx;
   logic              redir_q;
   logic [SR_W-1:0]   sr_q, sr_nx, rd_sr;
   logic [PC_W-1:0]   pc_q, pc_nx, rd_pc;
   logic [3:0]        irq_ack_q;
   logic [NUM_EXC-1:0] exc_ack_q;
   logic              dbg_ack_q;
   logic              wr_en;
   logic [SLOT_W-1:0] wr_slot, rd_slot;

   evt_arb #(
      .SR_W(SR_W), .NUM_EXC(NUM_EXC), .EXC_LOW_FIRST(EXC_LOW_FIRST)
   ) u_arb (
      .hold(redir_q), .sr(sr_in), .irq_req(irq_req), .exc_req(exc_req),
      .dbg_req(dbg_req), .ev_ret(ev_ret), .dbg_ret(dbg_ret),
      .ev(ev), .lvl(lvl), .exc_idx(exc_idx)
   );

   evt_ctx_store #(.PC_W(PC_W), .SR_W(SR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_sr(sr_in), .wr_pc(pc_in), .rd_slot(rd_slot),
      .rd_sr(rd_sr), .rd_pc(rd_pc)
   );

   always_comb begin
      wr_en   = 1'b0;
      wr_slot = '0;
      rd_slot = '0;
      sr_nx   = sr_in;
      pc_nx   = pc_in;
      case (ev)
         EV_RETD: begin
            rd_slot = SLOT_W'(SLOT_DBG);
            sr_nx   = rd_sr;
            pc_nx   = rd_pc;
         end
         EV_RETE: begin
            rd_slot = sr_in[2:0] - 3'd2;
            sr_nx   = rd_sr;
            pc_nx   = rd_pc;
         end
         EV_DBG: begin
            wr_en          = 1'b1;
            wr_slot        = SLOT_W'(SLOT_DBG);
            sr_nx[SR_DBG]  = 1'b1;
            sr_nx[2:0]     = MD_EXC;
            pc_nx          = PC_W'(DBG_VEC);
         end
         EV_EXC: begin
            wr_en         = 1'b1;
            wr_slot       = SLOT_W'(SLOT_EXC);
            sr_nx[2:0]    = MD_EXC;
            sr_nx[SR_EM]  = 1'b1;
            sr_nx[SR_GM]  = 1'b1;
            pc_nx         = PC_W'(EXC_BASE) + PC_W'(exc_idx) * PC_W'(VEC_STRIDE);
         end
         EV_INT: begin
            wr_en      = 1'b1;
            wr_slot    = {1'b0, lvl};
            sr_nx[2:0] = 3'd2 + {1'b0, lvl};
            pc_nx      = PC_W'(INT_BASE) + PC_W'(lvl) * PC_W'(VEC_STRIDE);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_q   <= 1'b0;
         sr_q      <= '0;
         pc_q      <= '0;
         irq_ack_q <= '0;
         exc_ack_q <= '0;
         dbg_ack_q <= 1'b0;
      end else begin
         redir_q   <= (ev != EV_NONE);
         irq_ack_q <= (ev == EV_INT) ? (4'b0001 << lvl) : 4'b0000;
         exc_ack_q <= (ev == EV_EXC) ? (NUM_EXC'(1) << exc_idx) : '0;
         dbg_ack_q <= (ev == EV_DBG);
         if (ev != EV_NONE) begin
            sr_q <= sr_nx;
            pc_q <= pc_nx;
         end
      end
   end

   assign redir_vld = redir_q;
   assign sr_out    = sr_q;
   assign pc_out    = pc_q;
   assign irq_ack   = irq_ack_q;
   assign exc_ack   = exc_ack_q;
   assign dbg_ack   = dbg_ack_q;

   // R2
   redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_q |=> !redir_q);

   // R2
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dbg_ack_q, exc_ack_q, irq_ack_q}));

   // R11
   ack_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|{dbg_ack_q, exc_ack_q, irq_ack_q}) |-> redir_q);

   // R6
   exc_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_ack_q) |-> (sr_q[2:0] == MD_EXC && sr_q[SR_EM] && sr_q[SR_GM]));

   // R5
   dbg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack_q |-> $past(!sr_in[SR_DM] && !sr_in[SR_DBG]));

   // R7
   irq_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack_q) |-> (mode_rank(sr_q[2:0]) > $past(mode_rank(sr_in[2:0]))));
endmodule

// File: tb/sim_evt_ctl.sv
`timescale 1ns/1ps
module sim_evt_ctl;
   localparam int NE  = 8;
   localparam int AW  = 1 + NE + 4;
   localparam logic [31:0] EXC_B = 32'h0000_0100;
   localparam logic [31:0] INT_B = 32'h0000_0200;
   localparam logic [31:0] STRD  = 32'd8;
   localparam logic [31:0] DVEC  = 32'h0000_0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_req = '0;
   logic [NE-1:0] exc_req = '0;
   logic        dbg_req = 1'b0, ev_ret = 1'b0, dbg_ret = 1'b0;
   logic [15:0] sr_in = '0;
   logic [31:0] pc_in = '0;
   logic        redir_vld;
   logic [15:0] sr_out;
   logic [31:0] pc_out;
   logic [3:0]  irq_ack;
   logic [NE-1:0] exc_ack;
   logic        dbg_ack;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_rs [6];
   logic [31:0] m_ra [6];

   always #2.5 clk = ~clk;

   evt_ctl #(
      .PC_W(32), .SR_W(16), .NUM_EXC(NE), .EXC_LOW_FIRST(1),
      .EXC_BASE(EXC_B), .INT_BASE(INT_B), .VEC_STRIDE(STRD), .DBG_VEC(DVEC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .exc_req(exc_req),
      .dbg_req(dbg_req), .ev_ret(ev_ret), .dbg_ret(dbg_ret),
      .sr_in(sr_in), .pc_in(pc_in), .redir_vld(redir_vld),
      .sr_out(sr_out), .pc_out(pc_out), .irq_ack(irq_ack),
      .exc_ack(exc_ack), .dbg_ack(dbg_ack)
   );

   task automatic chk(input bit ok, input string rq,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, expv);
      end
   endtask

   function automatic int rank_of(input logic [2:0] md);
      case (md)
         3'd0, 3'd1: return 0;
         3'd6:       return 5;
         3'd7:       return 7;
         default:    return int'(md) - 1;
      endcase
   endfunction

   // one transaction: drive, check redirect cycle, check the ignored cycle
   task automatic step(input logic [3:0] ir, input logic [NE-1:0] er,
                       input logic dr, input logic rte, input logic rtd,
                       input logic [15:0] sr, input logic [31:0] pc);
      int kind = 0;
      int ei = -1;
      int lv = -1;
      int slot = 0;
      logic [15:0] esr = sr;
      logic [31:0] epc = pc;
      logic [AW-1:0] eack = '0;
      logic [2:0] md = sr[2:0];
      for (int i = NE - 1; i >= 0; i--) if (er[i]) ei = i;
      for (int k = 0; k < 4; k++)
         if (ir[k] && !sr[3] && !sr[4+k] && (k + 1) > rank_of(md)) lv = k;
      if (rtd && sr[10]) kind = 1;
      else if (rte && md >= 3'd2 && md <= 3'd6) kind = 2;
      else if (dr && !sr[9] && !sr[10]) kind = 3;
      else if (ei >= 0 && !sr[8]) kind = 4;
      else if (lv >= 0) kind = 5;
      case (kind)
         1: begin esr = m_rs[5]; epc = m_ra[5]; end
         2: begin esr = m_rs[int'(md) - 2]; epc = m_ra[int'(md) - 2]; end
         3: begin esr[10] = 1'b1; esr[2:0] = 3'd6; epc = DVEC; slot = 5;
                  eack[AW-1] = 1'b1; end
         4: begin esr[2:0] = 3'd6; esr[8] = 1'b1; esr[3] = 1'b1;
                  epc = EXC_B + 32'(ei) * STRD; slot = 4; eack[4+ei] = 1'b1; end
         5: begin esr[2:0] = 3'(2 + lv); epc = INT_B + 32'(lv) * STRD;
                  slot = lv; eack[lv] = 1'b1; end
         default: ;
      endcase
      irq_req = ir; exc_req = er; dbg_req = dr; ev_ret = rte; dbg_ret = rtd;
      sr_in = sr; pc_in = pc;
      @(posedge clk); @(negedge clk);
      // R2 R3
      chk(redir_vld == (kind != 0), "R2/R3 redirect", 64'(redir_vld), 64'(kind != 0));
      // R11 acknowledges
      chk({dbg_ack, exc_ack, irq_ack} == eack, "R11 ack", 64'({dbg_ack, exc_ack, irq_ack}), 64'(eack));
      if (kind != 0) begin
         // R4 R6 R7 R9 R10
         chk(sr_out == esr, "R4/R6/R7/R9/R10 sr_out", 64'(sr_out), 64'(esr));
         chk(pc_out == epc, "R4/R6/R7/R9/R10 pc_out", 64'(pc_out), 64'(epc));
      end
      @(posedge clk); @(negedge clk);
      // R2 inputs held during the redirect cycle must be ignored
      if (kind != 0)
         chk(redir_vld == 1'b0 && {dbg_ack, exc_ack, irq_ack} == '0,
             "R2 hold", 64'(redir_vld), 64'd0);
      irq_req = '0; exc_req = '0; dbg_req = 1'b0; ev_ret = 1'b0; dbg_ret = 1'b0;
      if (kind >= 3) begin m_rs[slot] = sr; m_ra[slot] = pc; end  // R8 model
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      for (int s = 0; s < 6; s++) begin m_rs[s] = '0; m_ra[s] = '0; end
      repeat (3) @(negedge clk);
      // R1
      chk(redir_vld == 1'b0, "R1 redir", 64'(redir_vld), 64'd0);
      chk({dbg_ack, exc_ack, irq_ack} == '0, "R1 ack", 64'({dbg_ack, exc_ack, irq_ack}), 64'd0);
      chk(sr_out == '0, "R1 sr_out", 64'(sr_out), 64'd0);
      chk(pc_out == '0, "R1 pc_out", 64'(pc_out), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 masked debug, then debug already active
      step(4'h0, '0, 1'b1, 1'b0, 1'b0, 16'h0200, 32'h1000);
      step(4'h0, '0, 1'b1, 1'b0, 1'b0, 16'h0406, 32'h1004);
      // R7 R8 level 1 from application, then R9 return
      step(4'h2, '0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0100);
      step(4'h0, '0, 1'b0, 1'b1, 1'b0, 16'h0003, 32'h0000_0204);
      // R7 equal level held off, higher level taken
      step(4'h4, '0, 1'b0, 1'b0, 1'b0, 16'h0004, 32'h2000);
      step(4'hC, '0, 1'b0, 1'b0, 1'b0, 16'h0004, 32'h2004);
      // R7 masked level skipped for lower one
      step(4'hA, '0, 1'b0, 1'b0, 1'b0, 16'h0080, 32'h2008);
      // R3 return wins over a new exception
      step(4'h0, 8'h10, 1'b0, 1'b1, 1'b0, 16'h0005, 32'h3000);
      // R6 exception, lowest index wins
      step(4'hF, 8'h6C, 1'b0, 1'b0, 1'b0, 16'h0001, 32'h4000);
      // R4 debug from exception mode, R10 return, R8 exception pair intact
      step(4'h0, 8'h01, 1'b1, 1'b0, 1'b0, 16'h0106, 32'h5000);
      step(4'h0, '0, 1'b0, 1'b0, 1'b1, 16'h0406, 32'h0000_0090);
      step(4'h0, '0, 1'b0, 1'b1, 1'b0, 16'h0106, 32'h5000);
      // R10 debug return with debug flag clear, R9 return in application mode
      step(4'h0, '0, 1'b0, 1'b0, 1'b1, 16'h0006, 32'h6000);
      step(4'h0, '0, 1'b0, 1'b1, 1'b0, 16'h0000, 32'h6004);
      step(4'h0, '0, 1'b0, 1'b1, 1'b0, 16'h0007, 32'h6008);

      for (int n = 0; n < 400; n++) begin
         logic [15:0] rsr = 16'($urandom) & 16'h07FF;
         if ($urandom_range(0, 1) == 0) rsr[10:8] = 3'b000;
         if ($urandom_range(0, 1) == 0) rsr[7:3] = 5'b00000;
         step(4'($urandom), NE'($urandom & $urandom & $urandom),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
              ($urandom_range(0, 4) == 0), rsr, $urandom);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule